// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Manager

This block keeps an asynchronous DRAM's contents alive and brings the device up after power-on. It turns a system clock into a periodic refresh tick and asks a memory sequencer for refresh cycles through a request/grant pair. The sequencer drives the DRAM pins. This block only decides when a refresh is owed and, for RAS-only refresh, which row it targets.

After reset the block raises no request for a fixed power-up pause. It then asks for a burst of wake-up cycles, and only after that burst does it declare the memory ready. Refresh requests that the sequencer cannot serve at once are held in a small backlog. If the backlog overflows, the refresh deadline counts as missed. The block then raises a sticky flag, withdraws ready and runs the wake-up burst again.

A mode input picks the refresh style. In CBR style (CAS held low as RAS falls) the DRAM uses its own row counter and the row output is not used. In RAS-only style the sequencer places `ref_row` on the address pins, and the block steps that row after every granted cycle.

Top module: `dram_refresh_mgr`

## Requirements
- R1: While reset is held, and right after it, `ref_req`, `mem_ready` and `deadline_missed` are 0 and `ref_row` is 0.
- R2: After reset is released, `ref_req` stays 0 for PAUSE_CYC = CLK_KHZ*PAUSE_US/1000 clock edges. It first reads 1 after edge number PAUSE_CYC.
- R3: After the pause, `ref_req` stays 1 until WAKE_CYCLES grants have been taken, while `mem_ready` stays 0. `mem_ready` reads 1 right after the edge that takes the last wake-up grant.
- R4: While ready, a tick occurs every TICK_CYC = floor(CLK_KHZ*REFRESH_MS / 2^ROW_BITS) cycles. The first tick makes `ref_req` read 1 exactly TICK_CYC edges after `mem_ready` rose.
- R5: Each tick adds one pending refresh and each grant retires one. A grant is an edge with `ref_req` and `ref_grant` both 1. `ref_req` is 1 exactly while refreshes are pending. `ref_grant` while `ref_req` is 0 has no effect.
- R6: A tick that arrives with MAX_PEND refreshes already pending and no grant on that edge causes an overflow. From the next cycle `deadline_missed` is 1, `mem_ready` is 0 and `ref_req` is 1. The backlog is cleared.
- R7: `deadline_missed` stays 1 until reset, and reset clears it.
- R8: With `mode_ras_only` = 1, each grant advances `ref_row` by one on that edge. The row wraps from 2^ROW_BITS-1 to 0.
- R9: With `mode_ras_only` = 0 (CBR refresh), grants leave `ref_row` unchanged.
- R10: After an overflow the full WAKE_CYCLES burst is repeated before `mem_ready` returns. These wake-up cycles advance the row like any other refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ras_only | input | 1 | 1: RAS-only refresh with `ref_row`; 0: CBR refresh |
| ref_grant | input | 1 | Sequencer accepts the current refresh request |
| ref_req | output | 1 | A refresh or wake-up cycle is wanted |
| ref_row | output | ROW_BITS | Row for the next RAS-only refresh |
| mem_ready | output | 1 | Pause and wake-up done; normal traffic allowed |
| deadline_missed | output | 1 | Sticky: the refresh backlog overflowed |

## Verification
The bench measures the pause and the first tick interval to the exact edge. A timer that is off by one would make the first request appear one cycle early or late. It leaves ticks unserved until the backlog is exactly full and then checks the cycle before and the cycle after the overflowing tick. A design with the wrong backlog depth would flag too early, or never. The wake-up cycles run in RAS-only mode, so the row wraps past 2^ROW_BITS. A row counter that saturates, or skips wake-up cycles, ends on a different value. A design that counts grants without a request, or steps the row in CBR mode, shows a moved row.

// File: rtl/dram_refresh_mgr.sv
module dram_refresh_mgr #(
  parameter int CLK_KHZ     = 100000,
  parameter int REFRESH_MS  = 32,
  parameter int ROW_BITS    = 11,
  parameter int PAUSE_US    = 200,
  parameter int WAKE_CYCLES = 8,
  parameter int MAX_PEND    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_ras_only,
  input  logic                ref_grant,
  output logic                ref_req,
  output logic [ROW_BITS-1:0] ref_row,
  output logic                mem_ready,
  output logic                deadline_missed
);
  localparam int TICK_CYC  = (CLK_KHZ * REFRESH_MS) >> ROW_BITS;
  localparam int PAUSE_CYC = CLK_KHZ * PAUSE_US / 1000;
  localparam int TMR_MAX   = (TICK_CYC > PAUSE_CYC) ? TICK_CYC : PAUSE_CYC;
  localparam int TW        = $clog2(TMR_MAX + 1);
  localparam int PW        = $clog2(MAX_PEND + 1);
  localparam int WW        = $clog2(WAKE_CYCLES + 1);

  typedef enum logic [1:0] {S_PAUSE, S_WAKE, S_RUN} state_t;
  state_t        st;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pend;
  logic [WW-1:0] wake_left;

  wire take      = ref_req & ref_grant;
  wire tick      = (st == S_RUN) && (tmr == TW'(TICK_CYC - 1));
  wire pause_end = (st == S_PAUSE) && (tmr == TW'(PAUSE_CYC - 1));
  wire overflow  = tick && (pend == PW'(MAX_PEND)) && !take;

  assign ref_req   = (st == S_WAKE) || ((st == S_RUN) && (pend != '0));
  assign mem_ready = (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= S_PAUSE;
      tmr             <= '0;
      pend            <= '0;
      wake_left       <= '0;
      deadline_missed <= 1'b0;
    end else begin
      case (st)
        S_PAUSE: begin
          if (pause_end) begin
            st        <= S_WAKE;
            tmr       <= '0;
            wake_left <= WW'(WAKE_CYCLES);
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        S_WAKE: begin
          if (take) begin
            wake_left <= wake_left - WW'(1);
            if (wake_left == WW'(1)) begin
              st   <= S_RUN;
              tmr  <= '0;
              pend <= '0;
            end
          end
        end
        default: begin
          if (overflow) begin
            st              <= S_WAKE;
            deadline_missed <= 1'b1;
            wake_left       <= WW'(WAKE_CYCLES);
            pend            <= '0;
            tmr             <= '0;
          end else begin
            tmr  <= tick ? '0 : tmr + TW'(1);
            pend <= pend + PW'(tick) - PW'(take);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ref_row <= '0;
    else if (take && mode_ras_only) ref_row <= ref_row + ROW_BITS'(1);
  end

  // R8
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_grant && mode_ras_only) |=> ref_row == ROW_BITS'($past(ref_row) + 1));
  // R9
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_req && ref_grant && mode_ras_only) |=> $stable(ref_row));
  // R7
  missed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deadline_missed |=> deadline_missed);
  // R6
  missed_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadline_missed) |-> (!mem_ready && ref_req));
  // R3
  ready_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> $past(ref_req && ref_grant));
endmodule

// File: tb/dram_refresh_mgr_test.sv
`timescale 1ns/1ps
module dram_refresh_mgr_test;
  localparam int CLK_KHZ = 1000, REFRESH_MS = 1, ROW_BITS = 4;
  localparam int PAUSE_US = 20, WAKE = 8, MAXP = 4;
  localparam int TICK  = (CLK_KHZ * REFRESH_MS) / (1 << ROW_BITS);
  localparam int PAUSE = CLK_KHZ * PAUSE_US / 1000;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b1, grant = 1'b0;
  logic req, ready, missed;
  logic [ROW_BITS-1:0] row;
  int errors = 0, checks = 0, n, g;

  always #2.5 clk = ~clk;

  dram_refresh_mgr #(.CLK_KHZ(CLK_KHZ), .REFRESH_MS(REFRESH_MS), .ROW_BITS(ROW_BITS),
    .PAUSE_US(PAUSE_US), .WAKE_CYCLES(WAKE), .MAX_PEND(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .mode_ras_only(mode), .ref_grant(grant),
    .ref_req(req), .ref_row(row), .mem_ready(ready), .deadline_missed(missed));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic grant_until_ready(output int takes);
    takes = 0;
    grant = 1'b1;
    for (int i = 0; i < 100; i++) begin
      if (req && grant) takes++;
      @(negedge clk);
      if (ready) break;
      chk("R3 ready low during wake", ready, 0);
    end
    grant = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req", req, 0); chk("R1 ready", ready, 0);
    chk("R1 missed", missed, 0); chk("R1 row", row, 0);
    rst_n = 1'b1;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); n++;
      if (req) break;
    end
    chk("R2 pause length", n, PAUSE);
    chk("R2 ready low after pause", ready, 0);

    grant_until_ready(g);
    chk("R3 wake grants", g, WAKE);
    chk("R8 row after wake", row, WAKE);

    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); n++;
      if (req) break;
    end
    chk("R4 first tick", n, TICK);

    repeat (2 * TICK + 1) @(negedge clk);
    grant = 1'b1; g = 0;
    for (int i = 0; i < 20; i++) begin
      if (req && grant) g++;
      @(negedge clk);
      if (!req) break;
    end
    grant = 1'b0;
    chk("R5 backlog drained", g, 3);
    chk("R8 row after drain", row, WAKE + 3);

    grant = 1'b1;
    repeat (5) @(negedge clk);
    grant = 1'b0;
    chk("R5 idle grant row", row, WAKE + 3);
    chk("R5 idle grant req", req, 0);

    mode = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (req) break;
    end
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    chk("R9 CBR row held", row, WAKE + 3);
    chk("R9 CBR req retired", req, 0);
    mode = 1'b1;

    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (req) break;
    end
    repeat (MAXP * TICK - 1) @(negedge clk);
    chk("R6 ready before overflow", ready, 1);
    chk("R6 missed before overflow", missed, 0);
    @(negedge clk);
    chk("R6 missed after overflow", missed, 1);
    chk("R6 ready after overflow", ready, 0);
    chk("R6 req after overflow", req, 1);

    grant_until_ready(g);
    chk("R10 rewake grants", g, WAKE);
    chk("R7 missed sticky", missed, 1);
    chk("R8 row wrapped", row, (2 * WAKE + 3) % (1 << ROW_BITS));

    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 reset clears missed", missed, 0);
    chk("R1 reset row", row, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule